// File: doc/BRIEF.md
# Programmable Periodic Timebase Interrupt Generator

The block divides a reference tick stream by a selectable power of two and raises a sticky event flag each time its internal counter passes the chosen boundary. Software configures it through one 8-bit control/status register on a simple synchronous register bus. The bus has a write strobe that is already address-decoded, a write data byte and a read data byte. The block drives an interrupt request whenever the event flag is set and interrupts are enabled.

A three-bit rate code picks the divide ratio. Larger codes give faster events. The ratio is 2^(CNT_W − code), so the default 18-bit counter spans 262144 ticks at code 0 down to 2048 ticks at code 7. Software clears the flag by writing 1 to the acknowledge bit. Turning the enable bit off and back on restarts the count from zero. The rate code should only be changed while the counter is disabled.

Top module: `tbase_irq_gen`

## Requirements
- R1: With the timebase enabled and a tick on every cycle, the flag is set once every 2^(CNT_W − code) cycles. Code 0 gives the longest period; with the default CNT_W = 18, codes 0..7 give 262144, 131072, 65536, 32768, 16384, 8192, 4096 and 2048 ticks.
- R2: The counter advances by one only on cycles where `ref_tick` is 1 and the timebase is enabled. Cycles without a tick do not count toward the period.
- R3: `irq` is 1 exactly when the flag and the interrupt-enable bit are both 1, as seen from the cycle after the edge that set them.
- R4: Writing 1 to bit 3 (the acknowledge bit) clears the flag. Writing 0 to bit 3 leaves the flag unchanged. Bit 3 always reads as 0.
- R5: While bit 1 (enable) is 0, the counter is held at zero. After the timebase is re-enabled, the first flag arrives a full period after the enabling write.
- R6: Synchronous reset clears the flag, the rate code, interrupt enable, timebase enable, the counter and `irq`. After reset the register reads 0x00.
- R7: The register layout is: bit 7 flag, bits 6:4 rate code, bit 3 acknowledge, bit 2 interrupt enable, bit 1 timebase enable, bit 0 reads 0. A write updates the rate code, interrupt enable and timebase enable together.
- R8: When a rollover and an acknowledge write happen in the same cycle, the flag stays set.
- R9: Bit 7 is read-only. Writing 1 to it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, one count per high cycle |
| reg_we | input | 1 | Decoded write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the control/status register |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the in-RTL assertions check how the counter steps and how it holds at zero while disabled. They also check that a rollover sets the flag, that an acknowledge clears it, that a rollover beats a simultaneous acknowledge, that reset clears the controls, and that the registered request agrees with the flag and enable.

Only the bench's scenarios can show the actual period for each rate code, the full-period restart after a disable, the stretched period under sparse ticks, and the read-back layout. The bench checks these with a behavioural model compared every clock, using a 10-bit counter so that every code fits in a short run.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int RATE_W = 3;
  localparam int NCODE  = 1 << RATE_W;
  localparam int REG_W  = 8;

  localparam int B_FLAG = 7;
  localparam int B_RATE = 4;
  localparam int B_ACK  = 3;
  localparam int B_IE   = 2;
  localparam int B_EN   = 1;

  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    rate_t rate;
    logic  ie;
    logic  en;
  } ctl_t;
endpackage

// File: rtl/tbase_ctrl_reg.sv
module tbase_ctrl_reg
  import tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic             ie_nxt,
  output logic             ack
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) begin
      ctl_d.rate = wdata[B_RATE +: RATE_W];
      ctl_d.ie   = wdata[B_IE];
      ctl_d.en   = wdata[B_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assign ie_nxt = ctl_d.ie;
  assign ack    = we & wdata[B_ACK];

  // R6: reset leaves every control field cleared
  p_reset_clear_r6: assert property (@(posedge clk) rst |=> (ctl_q == '0));
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  tick,
  input  rate_t rate,
  output logic  roll
);
  logic [CNT_W-1:0] cnt_q;
  logic [NCODE-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // one all-ones detector per rate code; code c watches the low CNT_W-c bits
  for (genvar c = 0; c < NCODE; c++) begin : g_rate
    localparam int LEN = CNT_W - c;
    assign hit[c] = &cnt_q[LEN-1:0];
  end

  assign roll = en & tick & hit[rate];

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
  input  logic clk,
  input  logic rst,
  input  logic roll,
  input  logic ack,
  output logic flag_q,
  output logic flag_nxt
);
  always_comb begin
    flag_nxt = flag_q;
    if (roll)     flag_nxt = 1'b1;
    else if (ack) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

  p_roll_sets_r1: assert property (@(posedge clk) disable iff (rst)
    roll |=> flag_q);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && !roll) |=> !flag_q);
  p_roll_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && roll) |=> flag_q);
endmodule

// File: rtl/tbase_irq_gen.sv
module tbase_irq_gen
  import tbase_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  ctl_t ctl_q;
  logic ie_nxt, ack, roll, flag_q, flag_nxt, irq_q;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[B_FLAG], reg_wdata[0]};

  tbase_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .ctl_q(ctl_q), .ie_nxt(ie_nxt), .ack(ack)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctl_q.en), .tick(ref_tick),
    .rate(ctl_q.rate), .roll(roll)
  );

  tbase_flag u_flag (
    .clk(clk), .rst(rst), .roll(roll), .ack(ack),
    .flag_q(flag_q), .flag_nxt(flag_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_nxt & ie_nxt;
  end

  always_comb begin
    reg_rdata                    = '0;
    reg_rdata[B_FLAG]            = flag_q;
    reg_rdata[B_RATE +: RATE_W]  = ctl_q.rate;
    reg_rdata[B_IE]              = ctl_q.ie;
    reg_rdata[B_EN]              = ctl_q.en;
  end

  assign irq = irq_q;

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q & ctl_q.ie));
endmodule

// File: tb/tbase_irq_gen_bench.sv
`timescale 1ns/1ps
module tbase_irq_gen_bench;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       tick_alt = 1'b0;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R6";
  bit    done = 0;

  // behavioural reference model
  int m_cnt = 0, m_rate = 0, m_ratio = 0;
  bit m_flag = 0, m_ie = 0, m_en = 0, m_irq = 0, m_roll = 0;

  tbase_irq_gen #(.CNT_W(CW)) u_tbase_irq_gen (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic int ratio_of(int code);
    return 1 << (CW - code);
  endfunction

  function automatic logic [7:0] ctl(int rate, bit ackb, bit ie, bit en);
    logic [2:0] r = rate[2:0];
    return {1'b0, r, ackb, ie, en, 1'b0};
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_ie = 0; m_en = 0; m_rate = 0;
    end else begin
      m_ratio = ratio_of(m_rate);
      m_roll  = m_en && ref_tick && ((m_cnt % m_ratio) == m_ratio - 1);
      if (!m_en)         m_cnt = 0;
      else if (ref_tick) m_cnt = (m_cnt + 1) % (1 << CW);
      if (m_roll)                        m_flag = 1;
      else if (reg_we && reg_wdata[3])   m_flag = 0;
      if (reg_we) begin
        m_rate = int'(reg_wdata[6:4]);
        m_ie   = reg_wdata[2];
        m_en   = reg_wdata[1];
      end
    end
    m_irq = m_flag && m_ie;
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (reg_rdata !== {m_flag, m_rate[2:0], 1'b0, m_ie, m_en, 1'b0} || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", phase,
                 reg_rdata, irq, {m_flag, m_rate[2:0], 1'b0, m_ie, m_en, 1'b0}, m_irq);
      end
    end
  end

  always @(negedge clk) begin
    if (tick_alt) ref_tick <= ~ref_tick;
    else          ref_tick <= 1'b1;
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_flag(string tag, output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reg_rdata[7] && n < 5000);
    t = cyc;
    if (n >= 5000) chk(tag, 0, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  initial begin
    int t0, t1, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase = "R6";
    chk("R6 reset rdata", int'(reg_rdata), 0);
    chk("R6 reset irq", int'(irq), 0);

    phase = "R7";
    wr(ctl(5, 0, 1, 0));
    chk("R7 readback", int'(reg_rdata), 8'h54);
    wr(ctl(2, 1, 0, 1));
    chk("R4 ack reads zero", int'(reg_rdata), 8'h22);

    phase = "R9";
    wr(8'h80 | ctl(3, 0, 0, 0));
    chk("R9 flag read-only", int'(reg_rdata), 8'h30);

    // R1 and R5: period for each code, first period counted from enable
    for (int code = 0; code < 8; code++) begin
      phase = "R1";
      wr(ctl(code, 1, 0, 0));
      wr(ctl(code, 0, 0, 1));
      t1 = cyc;
      wait_flag("R5", t0);
      chk("R5 first period after enable", t0 - t1, ratio_of(code));
      wr(ctl(code, 1, 0, 1));
      wait_flag("R1", t1);
      chk("R1 period", t1 - t0, ratio_of(code));
    end

    // R3 and R4 with the counter stopped
    phase = "R3";
    wr(ctl(7, 1, 0, 1));
    wait_flag("R3", t0);
    wr(ctl(7, 0, 0, 0));
    chk("R3 masked irq", int'(irq), 0);
    wr(ctl(7, 0, 1, 0));
    chk("R3 irq asserted", int'(irq), 1);
    phase = "R4";
    wr(ctl(7, 0, 1, 0));
    chk("R4 zero ack keeps flag", int'(reg_rdata[7]), 1);
    wr(ctl(7, 1, 1, 0));
    chk("R4 ack clears flag", int'(reg_rdata[7]), 0);
    chk("R3 irq drops after ack", int'(irq), 0);

    // R5: disable mid-count restarts from zero
    phase = "R5";
    wr(ctl(6, 0, 0, 1));
    repeat (5) @(negedge clk);
    wr(ctl(6, 0, 0, 0));
    wr(ctl(6, 0, 0, 1));
    t1 = cyc;
    wait_flag("R5", t0);
    chk("R5 restart period", t0 - t1, ratio_of(6));

    // R2: ticks on every other cycle double the period
    phase = "R2";
    tick_alt = 1'b1;
    wr(ctl(7, 1, 0, 1));
    wait_flag("R2", t0);
    wr(ctl(7, 1, 0, 1));
    wait_flag("R2", t1);
    chk("R2 sparse tick period", t1 - t0, 2 * ratio_of(7));
    tick_alt = 1'b0;
    @(negedge clk);

    // R8: acknowledge lands on the rollover edge
    phase = "R8";
    wr(ctl(7, 0, 1, 1));
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(m_en && ref_tick && (m_cnt % ratio_of(7)) == ratio_of(7) - 1) && n < 100);
    reg_we = 1'b1; reg_wdata = ctl(7, 1, 1, 1);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R8 rollover beats ack", int'(reg_rdata[7]), 1);
    chk("R8 irq stays", int'(irq), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule